// File: doc/BRIEF.md
# Receive Destination-Address Filter

This block sits on the receive path of an Ethernet MAC, after the preamble and start delimiter have been stripped. It takes a 4-bit nibble stream with a valid flag and advances one nibble per clock-enable strobe. Each byte arrives low nibble first, and bytes arrive in wire order. While it reads the first twelve nibbles (the destination address), it checks them against the station's own 48-bit address and against the all-ones broadcast address.

With filtering on, the destination address is dropped from the output, so the first nibble downstream belongs to the source address, which is followed by the EtherType. A destination that is neither the station nor broadcast raises an error flag that downstream logic can use to discard the frame. With filtering off, the stream passes through unchanged and no error is raised. In both modes the block flags frames sent to broadcast.

The filter setting is captured at the first nibble of a frame and holds until the valid flag falls. An abort input stops the frame in progress at once. The block then waits for the line to go idle before it accepts the next frame.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, `out_vld`, `addr_err` and `is_bcast` are 0.
- R2: With filtering off for a frame, every nibble accepted on a strobe with `in_vld` high appears on `out_nib` with `out_vld` high on the next clock edge, including the twelve address nibbles.
- R3: With filtering on, the first twelve nibbles of a frame give `out_vld` low. Nibble 13 onward is output one strobe later with `out_vld` high.
- R4: Nibble k (k = 0..11) of a frame is compared with byte k/2 of `station_addr`, where byte 0 is bits [47:40]. Even k is compared with the byte's low half and odd k with its high half. A frame whose twelve nibbles all match is accepted and leaves `addr_err` at 0.
- R5: With filtering on, a destination that matches neither the station address nor broadcast sets `addr_err` on the edge of the strobe that carries the twelfth nibble. The flag holds until a strobe with `in_vld` low.
- R6: With filtering off, `addr_err` is never set.
- R7: When all twelve address nibbles are 4'hF, `is_bcast` is set on the edge of the twelfth-nibble strobe, in either mode. It holds until a strobe with `in_vld` low, and such a frame never sets `addr_err`.
- R8: `filt_en` is sampled on the strobe that carries a frame's first nibble. Changes to it later in the same frame have no effect.
- R9: On a clock edge with `ce` low and `abort` low, all outputs hold and the input nibble is not taken.
- R10: `abort` high on any clock edge, whatever `ce` is, clears `out_vld`, `addr_err` and `is_bcast`. All later nibbles produce no output until a strobe sees `in_vld` low.
- R11: A strobe with `in_vld` low ends the frame: `out_vld`, `addr_err` and `is_bcast` are 0 after it, and the next valid nibble starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Nibble strobe; inputs are taken and outputs advance only when high |
| filt_en | input | 1 | Address filtering and stripping on, sampled at frame start |
| abort | input | 1 | Ends the current frame at once |
| station_addr | input | 48 | Station address; bits [47:40] are the first byte on the wire |
| in_vld | input | 1 | Input nibble valid, low between frames |
| in_nib | input | 4 | Input nibble |
| out_vld | output | 1 | Output nibble valid |
| out_nib | output | 4 | Output nibble |
| addr_err | output | 1 | Destination matches neither station nor broadcast (filter on) |
| is_bcast | output | 1 | Destination is the broadcast address |

## Verification
On every cycle the assertions check the following: held outputs while the strobe is low, the clearing effect of abort and of an idle strobe, silent output while address nibbles are stripped or after an abort, one-strobe pass-through of each nibble when the filter is off, and that an error is never raised together with broadcast or with the filter off. Only the bench scenarios can show that the address comparison uses the right nibble order. The same goes for the error and broadcast flags rising on exactly the twelfth nibble, and for a mid-frame change of `filt_en` being ignored. The bench shows these with a behavioural model that rebuilds the destination address from the queued nibbles.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  typedef logic [NIB_W-1:0] nib_t;

  // Broadcast nibble: every bit set
  function automatic logic nib_is_bcast(input nib_t n);
    return &n;
  endfunction

  // Bit offset of address nibble k (low half of a byte first, byte 0 at the top)
  function automatic int nib_offset(input int addr_w, input int k);
    return addr_w - BYTE_W * (k / 2 + 1) + NIB_W * (k % 2);
  endfunction
endpackage

// File: rtl/rx_da_seq.sv
module rx_da_seq
  import rx_da_filter_pkg::*;
#(
  parameter int HDR_NIBS = 12,
  parameter int CNT_W    = $clog2(HDR_NIBS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             abort,
  input  logic             in_vld,
  input  logic             filt_en,
  output logic [CNT_W-1:0] idx,
  output logic             hdr_phase,
  output logic             last_hdr,
  output logic             en_now,
  output logic             drop
);
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;
  logic             drop_q;

  assign idx       = cnt_q;
  assign hdr_phase = cnt_q < CNT_W'(HDR_NIBS);
  assign last_hdr  = cnt_q == CNT_W'(HDR_NIBS - 1);
  assign en_now    = (cnt_q == '0) ? filt_en : mode_q;
  assign drop      = drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
      drop_q <= 1'b0;
    end else if (abort) begin
      cnt_q  <= '0;
      drop_q <= 1'b1;
    end else if (ce) begin
      if (!in_vld) begin
        cnt_q  <= '0;
        drop_q <= 1'b0;
      end else if (!drop_q) begin
        if (cnt_q == '0) mode_q <= filt_en;
        if (hdr_phase) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8: once past the first nibble, the latched mode only changes at frame start
  a_r8_mode_held: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) && !abort && !(ce && !in_vld) |=> $stable(mode_q));

  // R10: after an abort the frame stays dropped until an idle strobe
  a_r10_drop_sticky: assert property (@(posedge clk) disable iff (rst)
    abort |=> drop_q);
endmodule

// File: rtl/rx_da_matcher.sv
module rx_da_matcher
  import rx_da_filter_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int HDR_NIBS = ADDR_W / NIB_W,
  parameter int CNT_W    = $clog2(HDR_NIBS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [CNT_W-1:0]  idx,
  input  nib_t              nib,
  input  logic [ADDR_W-1:0] station_addr,
  output logic              mine_nx,
  output logic              bc_nx
);
  nib_t exp_nib [HDR_NIBS];
  nib_t exp_cur;
  logic mine_q, bc_q;

  for (genvar g = 0; g < HDR_NIBS; g++) begin : g_nib
    localparam int OFS = nib_offset(ADDR_W, g);
    assign exp_nib[g] = station_addr[OFS +: NIB_W];
  end

  assign exp_cur = (idx < CNT_W'(HDR_NIBS)) ? exp_nib[idx] : '0;
  assign mine_nx = mine_q && (nib == exp_cur);
  assign bc_nx   = bc_q && nib_is_bcast(nib);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mine_q <= 1'b1;
      bc_q   <= 1'b1;
    end else if (take) begin
      mine_q <= mine_nx;
      bc_q   <= bc_nx;
    end
  end

  // R4: a nibble that differs from the station address kills the match for the frame
  a_r4_mismatch_sticky: assert property (@(posedge clk) disable iff (rst)
    take && !clear && (nib != exp_cur) |=> !mine_q);
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int HDR_NIBS = ADDR_W / NIB_W,
  parameter int CNT_W    = $clog2(HDR_NIBS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              filt_en,
  input  logic              abort,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              in_vld,
  input  logic [NIB_W-1:0]  in_nib,
  output logic              out_vld,
  output logic [NIB_W-1:0]  out_nib,
  output logic              addr_err,
  output logic              is_bcast
);
  logic [CNT_W-1:0] idx;
  logic hdr_phase, last_hdr, en_now, drop;
  logic mine_nx, bc_nx;
  logic frame_end, take, strip_now, decide, bad_dest;

  assign frame_end = ce && !in_vld;
  assign take      = ce && in_vld && !drop && !abort && hdr_phase;
  assign strip_now = en_now && hdr_phase;
  assign decide    = take && last_hdr;
  assign bad_dest  = en_now && !(mine_nx || bc_nx);

  rx_da_seq #(.HDR_NIBS(HDR_NIBS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .ce(ce), .abort(abort), .in_vld(in_vld),
    .filt_en(filt_en), .idx(idx), .hdr_phase(hdr_phase),
    .last_hdr(last_hdr), .en_now(en_now), .drop(drop)
  );

  rx_da_matcher #(.ADDR_W(ADDR_W), .HDR_NIBS(HDR_NIBS), .CNT_W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .clear(abort || frame_end), .take(take),
    .idx(idx), .nib(in_nib), .station_addr(station_addr),
    .mine_nx(mine_nx), .bc_nx(bc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      out_vld  <= 1'b0;
      out_nib  <= '0;
      addr_err <= 1'b0;
      is_bcast <= 1'b0;
    end else if (ce) begin
      if (!in_vld) begin
        out_vld  <= 1'b0;
        addr_err <= 1'b0;
        is_bcast <= 1'b0;
      end else if (drop) begin
        out_vld <= 1'b0;
      end else begin
        out_vld <= !strip_now;
        out_nib <= in_nib;
        if (decide) begin
          addr_err <= bad_dest;
          is_bcast <= bc_nx;
        end
      end
    end
  end

  // R9: no strobe, no change
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !ce && !abort |=> $stable(out_vld) && $stable(out_nib) &&
                      $stable(addr_err) && $stable(is_bcast));

  // R10: abort clears all outputs on the next edge
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort |=> !out_vld && !addr_err && !is_bcast);

  // R10: dropped nibbles never reach the output
  a_r10_drop_silent: assert property (@(posedge clk) disable iff (rst)
    ce && in_vld && drop && !abort |=> !out_vld);

  // R11: idle strobe ends the frame
  a_r11_idle_clears: assert property (@(posedge clk) disable iff (rst)
    ce && !in_vld && !abort |=> !out_vld && !addr_err && !is_bcast);

  // R3: address nibbles are stripped when filtering
  a_r3_strip: assert property (@(posedge clk) disable iff (rst)
    ce && in_vld && !drop && !abort && en_now && hdr_phase |=> !out_vld);

  // R2: pass-through with one strobe latency
  a_r2_pass: assert property (@(posedge clk) disable iff (rst)
    ce && in_vld && !drop && !abort && !en_now |=> out_vld && (out_nib == $past(in_nib)));

  // R7: broadcast never counts as an error
  a_r7_bcast_no_err: assert property (@(posedge clk) disable iff (rst)
    is_bcast |-> !addr_err);

  // R6: an error only rises on a filtered frame's deciding strobe
  a_r6_err_needs_filter: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_err) |-> $past(decide) && $past(en_now));
endmodule

// File: tb/rx_da_filter_test.sv
`timescale 1ns/1ps
module rx_da_filter_test;
  localparam logic [47:0] STA = 48'h02_1A_3C_5E_70_91;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, filt_en = 1'b0, abort = 1'b0, in_vld = 1'b0;
  logic [3:0] in_nib = '0;
  logic out_vld, addr_err, is_bcast;
  logic [3:0] out_nib;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  bit m_ov = 0, m_err = 0, m_bc = 0, m_mode = 0, m_drop = 0;
  logic [3:0] m_on = '0;
  logic [3:0] m_hdr[$];
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  rx_da_filter uut (
    .clk(clk), .rst(rst), .ce(ce), .filt_en(filt_en), .abort(abort),
    .station_addr(STA), .in_vld(in_vld), .in_nib(in_nib),
    .out_vld(out_vld), .out_nib(out_nib), .addr_err(addr_err), .is_bcast(is_bcast)
  );

  task automatic model_edge();
    logic [47:0] da;
    if (abort) begin
      m_ov = 0; m_err = 0; m_bc = 0; m_drop = 1; m_cnt = 0; m_hdr.delete();
    end else if (ce) begin
      if (!in_vld) begin
        m_ov = 0; m_err = 0; m_bc = 0; m_drop = 0; m_cnt = 0; m_hdr.delete();
      end else if (m_drop) begin
        m_ov = 0;
      end else if (m_cnt < 12) begin
        if (m_cnt == 0) m_mode = filt_en;
        m_hdr.push_back(in_nib);
        m_cnt++;
        m_ov = !m_mode;
        m_on = in_nib;
        if (m_cnt == 12) begin
          da = '0;
          for (int b = 0; b < 6; b++) da = {da[39:0], m_hdr[2*b+1], m_hdr[2*b]};
          m_bc  = (da == BC);
          m_err = m_mode && (da != STA) && !m_bc;
        end
      end else begin
        m_ov = 1; m_on = in_nib;
      end
    end
  endtask

  task automatic check(input string tag);
    n_cmp++;
    if (out_vld !== m_ov || addr_err !== m_err || is_bcast !== m_bc ||
        (m_ov && out_nib !== m_on)) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b nib=%h err=%0b bc=%0b, expected vld=%0b nib=%h err=%0b bc=%0b",
               tag, out_vld, out_nib, addr_err, is_bcast, m_ov, m_on, m_err, m_bc);
    end
  endtask

  task automatic step(input bit c, input bit v, input logic [3:0] n,
                      input bit e, input bit a, input string tag);
    ce = c; in_vld = v; in_nib = n; filt_en = e; abort = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [3:0] frame_nib(input logic [47:0] da, input int i);
    logic [7:0] by;
    if (i < 12) begin
      by = da[47 - 8*(i/2) -: 8];
      return (i % 2) ? by[7:4] : by[3:0];
    end
    return 4'((i * 7 + 3) & 15);
  endfunction

  task automatic send_frame(input logic [47:0] da, input int pay, input bit en,
                            input int flip_at, input bit gaps, input string tag);
    for (int i = 0; i < 12 + pay; i++) begin
      bit e;
      e = (i >= flip_at) ? !en : en;
      if (gaps) step(0, 1, frame_nib(da, i) ^ 4'hA, e, 0, "R9");
      step(1, 1, frame_nib(da, i), e, 0, tag);
    end
    step(1, 0, 4'h0, en, 0, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1");
    step(1, 0, 4'h0, 0, 0, "R1");
    // R2, R6: pass-through of a foreign frame
    send_frame(48'hA1B2_C3D4_E5F6, 8, 0, 99, 0, "R2");
    // R3, R4: filtered frame to the station
    send_frame(STA, 10, 1, 99, 0, "R3");
    // R5: mismatch only in the last nibble
    send_frame(STA ^ 48'h0000_0000_0010, 6, 1, 99, 0, "R5");
    // R4: nibbles of each byte swapped -> mismatch
    send_frame(48'h20A1_C3E5_0719, 4, 1, 99, 0, "R4");
    // R7: broadcast filtered and unfiltered
    send_frame(BC, 6, 1, 99, 0, "R7");
    send_frame(BC, 6, 0, 99, 0, "R7");
    // R6: foreign address with filter off
    send_frame(48'h1111_2222_3333, 3, 0, 99, 0, "R6");
    // R8: filt_en flips mid-frame both ways
    send_frame(48'h1111_2222_3333, 5, 1, 3, 0, "R8");
    send_frame(STA, 5, 0, 2, 0, "R8");
    // R9: strobe gaps with garbage nibbles
    send_frame(STA, 6, 1, 99, 1, "R9");
    // R10: abort mid-frame, with ce high and then ce low
    for (int i = 0; i < 5; i++) step(1, 1, frame_nib(STA, i), 1, 0, "R10");
    step(1, 1, frame_nib(STA, 5), 1, 1, "R10");
    for (int i = 6; i < 16; i++) step(1, 1, frame_nib(STA, i), 1, 0, "R10");
    step(1, 0, 4'h0, 1, 0, "R11");
    send_frame(48'hDEAD_BEEF_0001, 14, 1, 99, 0, "R10");
    for (int i = 0; i < 14; i++) step(1, 1, frame_nib(BC, i), 0, 0, "R10");
    step(0, 1, frame_nib(BC, 14), 0, 1, "R10");
    for (int i = 15; i < 18; i++) step(1, 1, frame_nib(BC, i), 0, 0, "R10");
    step(1, 0, 4'h0, 0, 0, "R11");
    // R11: short filtered frame then back-to-back frames
    send_frame(STA, -4, 1, 99, 0, "R11");
    send_frame(STA, 2, 1, 99, 0, "R11");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule